// File: doc/BRIEF.md
# Bit-Error Delay Training Controller

This block sets the receive sampling point of a parallel source-synchronous data bus. After a start request it walks an input delay setting through every tap it can take. At each tap it waits for the delay line to settle and takes one captured word as the seed of a local pattern generator. It then compares a fixed number of following words against the regenerated pattern and adds up the bit errors on all lanes. The transmitter is assumed to send a continuous PRBS7 stream.

When the sweep ends, the controller finds the longest run of error-free taps and loads the tap in the middle of that run into the delay line. Because every lane's errors count towards the same score, a tap passes only when all lanes sample cleanly. The chosen point is therefore the centre of the eye shared by the whole bus, and per-lane skew is tolerated. Seeding from a received word also fixes the word boundary at whatever phase the stream arrives with. If no tap is clean, the block reports failure and parks the delay at tap 0.

Top module: `delay_train_ctrl`

## Requirements
- R1: Out of reset, `done`, `fail` and `tap_load` are low, and `sel_tap` and `tap_value` are 0.
- R2: A start from idle or from the finished state loads the taps 0, 1, …, 63 in ascending order, each with a single-cycle `tap_load` pulse. One more pulse then loads the selected tap.
- R3: After each sweep load, the block waits 16 settle cycles, takes 1 seed word and compares 256 words. Consecutive sweep loads are therefore exactly 275 cycles apart.
- R4: The expected stream is the serial sequence s[n] = s[n-7] XOR s[n-6] (polynomial x^7+x^6+1). It is packed into words with bit 0 as the earliest bit. The checker seeds from the first word after settling, so any starting phase of the stream is accepted.
- R5: The score of a tap is the sum of mismatching bits over all lanes and all compared words. A tap passes only when its score is zero.
- R6: The selected tap is start + (length−1)/2, rounded down, of the longest run of consecutive passing taps. Between runs of equal length, the lower-index run wins.
- R7: When training ends, `done` rises with `sel_tap` equal to the tap loaded by the final pulse. Both hold until the next start.
- R8: If no tap passes, `fail` and `done` are both high and the final load and `sel_tap` are tap 0.
- R9: A start while the sweep is running has no effect: each run produces exactly 65 load pulses.
- R10: A start while `done` is high clears `done`, `fail` and `sel_tap` in the next cycle and begins a new sweep from tap 0.
- R11: The per-tap error score saturates at its maximum and never wraps. A tap with exactly 2^ERR_W errors still fails.
- R12: A passing run that reaches the last tap (63) is a candidate for selection like any other run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the captured bus words |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a training sweep |
| rx_data | input | DATA_W | Captured parallel bus word, one per cycle |
| tap_load | output | 1 | One-cycle strobe to load `tap_value` into the delay line |
| tap_value | output | TAP_W | Delay tap to load |
| done | output | 1 | Training finished; result valid |
| fail | output | 1 | No error-free tap was found |
| sel_tap | output | TAP_W | Tap chosen by training |

## Verification
The run tracker can close its best window in the same cycle that the sweep judges its final tap. In that case the longest-run update and the end-of-sweep decision land on one clock edge. This is provoked by a passing window that runs up to tap 63 and by a sweep where every tap passes. It is judged by the tap loaded in the final pulse and reported on `sel_tap`. Error saturation and the pass decision also meet in one judgement cycle. A tap injected with exactly 256 bit errors must still fail, which moves the chosen centre to a predictable value.

// File: rtl/dt_pkg.sv
// Package: shared types of the delay training controller.
// Assumes: nothing beyond the sequencer using these state codes.
package dt_pkg;

    // Phases of one training sweep
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_SETTLE = 3'd2,
        ST_SEED   = 3'd3,
        ST_MEAS   = 3'd4,
        ST_JUDGE  = 3'd5,
        ST_PICK   = 3'd6,
        ST_APPLY  = 3'd7
    } seq_state_t;

endpackage

// File: rtl/dt_prbs_checker.sv
// Module: regenerates the PRBS7 stream locally and counts bit errors.
// Seeding copies one received word into the reference. Each checked word
// is compared with the next pattern word, and the popcount of the
// mismatches goes into a saturating counter.
// Assumes: DATA_W >= 7, so that one word holds a full generator state.
module dt_prbs_checker #(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              check,
    input  logic [DATA_W-1:0] rx_data,
    output logic [ERR_W-1:0]  err_cnt
);
    localparam int EXT_W = 2 * DATA_W;
    localparam int POP_W = $clog2(DATA_W + 1);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] expect_w;
    logic [POP_W-1:0]  mism;
    logic [ERR_W:0]    sum_wide;

    // Extend the reference word by one word of the recurrence
    always_comb begin
        logic [EXT_W-1:0] ext;
        ext = '0;
        ext[DATA_W-1:0] = ref_q;
        for (int i = DATA_W; i < EXT_W; i++) begin
            ext[i] = ext[i-7] ^ ext[i-6];
        end
        expect_w = ext[EXT_W-1:DATA_W];
    end

    // Count the mismatching lanes of the current word
    always_comb begin
        mism = '0;
        for (int i = 0; i < DATA_W; i++) begin
            mism = mism + POP_W'(rx_data[i] ^ expect_w[i]);
        end
    end

    // Widened sum so that saturation can be detected
    always_comb begin
        sum_wide = {1'b0, err_cnt} + (ERR_W+1)'(mism);
    end

    // Reference word and saturating error counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            err_cnt <= '0;
        end else if (seed) begin
            ref_q   <= rx_data;
            err_cnt <= '0;
        end else if (check) begin
            ref_q   <= expect_w;
            err_cnt <= sum_wide[ERR_W] ? ERR_MAX : sum_wide[ERR_W-1:0];
        end
    end

endmodule

// File: rtl/dt_window_track.sv
// Module: follows the runs of passing taps while the sweep is in progress.
// It keeps the longest run so far and its start; a later run replaces the
// best one only when it is strictly longer, so ties stay with the lower
// taps. Reports the midpoint (rounded down) of the best run.
// Assumes: taps arrive in ascending order, one judgement per step.
module dt_window_track #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic             found,
    output logic [TAP_W-1:0] mid
);
    localparam int LEN_W = TAP_W + 1;

    logic [LEN_W-1:0] cur_len, best_len, cur_len_n;
    logic [TAP_W-1:0] cur_start, best_start, cur_start_n;
    logic [LEN_W-1:0] half_len;

    // Length and start of the current run if this tap passes
    always_comb begin
        cur_len_n   = cur_len + 1'b1;
        cur_start_n = (cur_len == '0) ? tap : cur_start;
    end

    // Current run and best run registers
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cur_len    <= '0;
            cur_start  <= '0;
            best_len   <= '0;
            best_start <= '0;
        end else if (step) begin
            if (pass) begin
                cur_len   <= cur_len_n;
                cur_start <= cur_start_n;
                if (cur_len_n > best_len) begin
                    best_len   <= cur_len_n;
                    best_start <= cur_start_n;
                end
            end else begin
                cur_len <= '0;
            end
        end
    end

    // Midpoint of the best run
    always_comb begin
        half_len = (best_len - 1'b1) >> 1;
        found    = (best_len != '0);
        mid      = best_start + half_len[TAP_W-1:0];
    end

endmodule

// File: rtl/dt_sequencer.sv
// Module: controls the sweep. Loads each tap, waits the settle time, seeds
// the checker, compares a block of words, judges the tap, and at the end
// loads the selected tap and raises done. Start is accepted only when idle
// or finished.
// Assumes: SETTLE >= 1 and WORDS >= 1.
module dt_sequencer
    import dt_pkg::*;
#(
    parameter int TAP_W  = 6,
    parameter int SETTLE = 16,
    parameter int WORDS  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             found,
    input  logic [TAP_W-1:0] mid,
    output logic             clear,
    output logic             seed_en,
    output logic             check_en,
    output logic             step_en,
    output logic             tap_load,
    output logic [TAP_W-1:0] tap_value,
    output logic             done,
    output logic             fail,
    output logic [TAP_W-1:0] sel_tap
);
    localparam int CNT_MAX = (WORDS > SETTLE) ? WORDS : SETTLE;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;
    localparam logic [TAP_W-1:0] TAP_LAST = '1;

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [TAP_W-1:0] tap_q;
    logic             accept;

    // A start counts only from idle or from a finished result
    always_comb begin
        accept = start && (state == ST_IDLE);
    end

    // Strobes decoded from the state
    always_comb begin
        clear     = accept;
        seed_en   = (state == ST_SEED);
        check_en  = (state == ST_MEAS);
        step_en   = (state == ST_JUDGE);
        tap_load  = (state == ST_LOAD) || (state == ST_APPLY);
        tap_value = tap_q;
    end

    // State, cycle counter and tap register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            tap_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        tap_q <= '0;
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cnt   <= '0;
                    state <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (cnt == CNT_W'(SETTLE - 1)) begin
                        state <= ST_SEED;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SEED: begin
                    cnt   <= '0;
                    state <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (cnt == CNT_W'(WORDS - 1)) begin
                        state <= ST_JUDGE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_JUDGE: begin
                    if (tap_q == TAP_LAST) begin
                        state <= ST_PICK;
                    end else begin
                        tap_q <= tap_q + 1'b1;
                        state <= ST_LOAD;
                    end
                end
                ST_PICK: begin
                    tap_q <= found ? mid : '0;
                    state <= ST_APPLY;
                end
                ST_APPLY: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Result registers: set when the final load is issued, cleared on start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            fail    <= 1'b0;
            sel_tap <= '0;
        end else if (accept) begin
            done    <= 1'b0;
            fail    <= 1'b0;
            sel_tap <= '0;
        end else if (state == ST_APPLY) begin
            done    <= 1'b1;
            fail    <= !found;
            sel_tap <= tap_q;
        end
    end

endmodule

// File: rtl/delay_train_ctrl.sv
// Module: top of the bit-error delay training controller. Connects the
// sweep sequencer, the PRBS7 error checker and the passing-run tracker.
// A tap passes when its saturated error score is zero.
// Assumes: rx_data is one captured word per clock from a PRBS7 source.
module delay_train_ctrl #(
    parameter int DATA_W = 8,
    parameter int TAP_W  = 6,
    parameter int SETTLE = 16,
    parameter int WORDS  = 256,
    parameter int ERR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] rx_data,
    output logic              tap_load,
    output logic [TAP_W-1:0]  tap_value,
    output logic              done,
    output logic              fail,
    output logic [TAP_W-1:0]  sel_tap
);
    logic             clear, seed_en, check_en, step_en;
    logic             found, tap_pass;
    logic [TAP_W-1:0] mid;
    logic [ERR_W-1:0] err_total;

    // Pass decision on the accumulated score
    always_comb begin
        tap_pass = (err_total == '0);
    end

    dt_sequencer #(
        .TAP_W (TAP_W),
        .SETTLE(SETTLE),
        .WORDS (WORDS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .found    (found),
        .mid      (mid),
        .clear    (clear),
        .seed_en  (seed_en),
        .check_en (check_en),
        .step_en  (step_en),
        .tap_load (tap_load),
        .tap_value(tap_value),
        .done     (done),
        .fail     (fail),
        .sel_tap  (sel_tap)
    );

    dt_prbs_checker #(
        .DATA_W(DATA_W),
        .ERR_W (ERR_W)
    ) u_chk (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed   (seed_en),
        .check  (check_en),
        .rx_data(rx_data),
        .err_cnt(err_total)
    );

    dt_window_track #(
        .TAP_W(TAP_W)
    ) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(clear),
        .step (step_en),
        .pass (tap_pass),
        .tap  (tap_value),
        .found(found),
        .mid  (mid)
    );

endmodule

// File: rtl/dt_train_sva.sv
// Checker: protocol properties of the delay training controller, bound to
// the top module.
module dt_train_sva #(
    parameter int TAP_W = 6,
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             tap_load,
    input logic [TAP_W-1:0] tap_value,
    input logic             done,
    input logic             fail,
    input logic [TAP_W-1:0] sel_tap,
    input logic             seed_en,
    input logic [ERR_W-1:0] err_total
);
    // R2: every load strobe lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tap_load |=> !tap_load);

    // R8: a failed training parks the delay at tap 0
    a_r8_fail_parks_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (sel_tap == '0 && tap_value == '0));

    // R7: the result holds until a new start
    a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(sel_tap) && $stable(fail)));

    // R10: a start after done clears the result
    a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && !fail && sel_tap == '0));

    // R11: a saturated score stays saturated until reseeded
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (err_total == '1 && !seed_en) |=> (err_total == '1));
endmodule

bind delay_train_ctrl dt_train_sva #(
    .TAP_W(TAP_W),
    .ERR_W(ERR_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tap_load (tap_load),
    .tap_value(tap_value),
    .done     (done),
    .fail     (fail),
    .sel_tap  (sel_tap),
    .seed_en  (seed_en),
    .err_total(err_total)
);

// File: tb/tb_delay_train_ctrl.sv
// Scoreboard bench: a driver task queues the expected loads and results,
// and a monitor pops and compares them as the design produces them.
module tb_delay_train_ctrl;
    localparam int DW = 8;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          tap_load, done, fail;
    logic [TW-1:0] tap_value, sel_tap;

    int checks = 0;
    int fails  = 0;
    int runs_done = 0;
    bit finished = 1'b0;

    logic [63:0] pass_mask = '0;
    logic [63:0] wrap_mask = '0;

    int exp_load_q[$];
    int exp_sel_q[$];
    int exp_fail_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    delay_train_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_data(rx_data),
        .tap_load(tap_load), .tap_value(tap_value),
        .done(done), .fail(fail), .sel_tap(sel_tap)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] span(input int lo, input int hi);
        logic [63:0] m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Delay-line and link model: clean PRBS7 at passing taps, sparse errors
    // at failing taps, exactly 256 bit errors at "wrap" taps.
    initial begin
        logic [6:0]    hist = 7'h35;
        logic [DW-1:0] w;
        int            cur_tap = 0;
        int            off = 0;
        forever begin
            @(negedge clk);
            if (tap_load) begin
                cur_tap = int'(tap_value);
                off = 0;
            end else if (off < 100000) begin
                off++;
            end
            for (int i = 0; i < DW; i++) begin
                w[i] = hist[6] ^ hist[5];
                hist = {hist[5:0], w[i]};
            end
            if (wrap_mask[cur_tap]) begin
                if (off >= 50 && off <= 177) w[1:0] = w[1:0] ^ 2'b11;
            end else if (!pass_mask[cur_tap]) begin
                if (off % 5 == 0) w[off % DW] = ~w[off % DW];
            end
            rx_data = w;
        end
    end

    // Monitor: compares load pulses and results against the queues
    initial begin
        int  cyc = 0, last_load = 0, loads = 0;
        bit  prev_done = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (tap_load) begin
                if (exp_load_q.size() == 0) begin
                    check_eq("R9", "unexpected load", int'(tap_value), -1);
                end else begin
                    check_eq("R2", "load value", int'(tap_value), exp_load_q.pop_front());
                end
                if (loads >= 1 && loads <= 63)
                    check_eq("R3", "load spacing", cyc - last_load, 275);
                last_load = cyc;
                loads++;
            end
            if (done && !prev_done) begin
                if (exp_sel_q.size() != 0) begin
                    string t = tag_q.pop_front();
                    check_eq(t, "selected tap", int'(sel_tap), exp_sel_q.pop_front());
                    check_eq("R8", "fail flag", int'(fail), exp_fail_q.pop_front());
                    check_eq("R7", "held tap equals sel", int'(tap_value), int'(sel_tap));
                    check_eq("R9", "loads per run", loads, 65);
                end
                loads = 0;
                runs_done++;
            end
            prev_done = done;
        end
    end

    // Driver: queue expectations, start the run, wait for it to end
    task automatic run_case(input logic [63:0] pm, input logic [63:0] wm,
                            input string tag, input bit poke);
        logic [63:0] ok = pm & ~wm;
        int best_s = 0, best_l = 0, s = 0, l = 0, sel, target;
        bit was_done;
        for (int t = 0; t < 64; t++) begin
            if (ok[t]) begin
                if (l == 0) s = t;
                l++;
                if (l > best_l) begin best_l = l; best_s = s; end
            end else l = 0;
        end
        sel = (best_l == 0) ? 0 : best_s + (best_l - 1) / 2;
        for (int t = 0; t < 64; t++) exp_load_q.push_back(t);
        exp_load_q.push_back(sel);
        exp_sel_q.push_back(sel);
        exp_fail_q.push_back(best_l == 0 ? 1 : 0);
        tag_q.push_back(tag);
        pass_mask = pm;
        wrap_mask = wm;
        target = runs_done + 1;
        was_done = done;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (was_done) begin
            // R10: result cleared one cycle after the restart
            check_eq("R10", "done cleared", int'(done), 0);
            check_eq("R10", "fail cleared", int'(fail), 0);
            check_eq("R10", "sel cleared", int'(sel_tap), 0);
        end
        if (poke) begin
            // R9: a start in mid-sweep must not restart it
            repeat (4000) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (runs_done < target) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_eq("R1", "done", int'(done), 0);
        check_eq("R1", "fail", int'(fail), 0);
        check_eq("R1", "tap_load", int'(tap_load), 0);
        check_eq("R1", "sel_tap", int'(sel_tap), 0);
        check_eq("R1", "tap_value", int'(tap_value), 0);
        run_case(span(10, 20), '0, "R5", 1'b0);                    // 15
        run_case(span(5, 9) | span(30, 34), '0, "R6", 1'b0);       // tie -> 7
        run_case(span(0, 2) | span(40, 47), '0, "R4", 1'b0);       // even -> 43
        run_case(span(58, 63), '0, "R12", 1'b0);                   // edge -> 60
        run_case('0, '0, "R8", 1'b0);                              // none -> fail
        run_case('1, span(20, 20), "R11", 1'b0);                   // wrap -> 42
        run_case('1, '0, "R12", 1'b1);                             // all -> 31
        check_eq("R2", "queue drained", exp_load_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule